// File: doc/BRIEF.md
# Parallel NOR Flash Command Interpreter

This block sits behind the bus port of a parallel NOR flash model and decodes its multi-cycle write command protocol. It keeps a write-cycle counter, the command currently in force and an 8-bit status register. It stores data into an internal byte-lane array for single-word programs and counted buffered writes. Sector erase is also supported: once a confirm byte arrives, a sweep engine overwrites a whole aligned sector with 0xFF, one bank word per clock. Any write sequence the decoder does not recognise drops the machine back to plain array reads.

The block also chooses what a read returns. A read gives array data, the status register, or zeros while the identifier or query mode is selected. The current read mode leaves the block on a port, so a separate formatter can supply identifier and query contents. Reads are registered: data appears one clock after the read strobe, qualified by a valid flag. Multi-byte data follows a byte order chosen by parameter. A narrow access reaches a single byte lane, selected by the low address bits.

Top module: `pflash_cmd_fsm`

## Requirements
- R1: After reset the read mode is array (read_mode = 0), the write-cycle counter is idle and the status register is 0x00.
- R2: A first-cycle command byte (bus_wdata[7:0]) of 0x10 or 0x40 arms a program. The next write stores its data at its address and sets status bit 7. Reads then return status until another command is given.
- R3: Command 0x20 or 0x28 followed by 0xD0 erases the sector containing the address, aligned down to SECTOR_BYTES, filling it with 0xFF. Words outside that sector are unchanged. Status bit 7 is cleared at the confirm and set again once the sweep of SECTOR_BYTES/BANK_BYTES cycles ends.
- R4: Command 0x20 or 0x28 followed by 0xFF aborts to array mode and changes no data.
- R5: With wr_protect high, a program stores nothing and sets status bits 4 and 7 (0x90). An erase confirm changes nothing and sets status bits 5 and 7 (0xA0).
- R6: Command 0x50 clears status. Command 0x70 selects status read (mode 1). Command 0x90 selects identifier mode (mode 2) and 0x98 selects query mode (mode 3); in both, reads return zero. Commands 0xFF and 0xF0 select array mode (mode 0).
- R7: Command 0xE8 sets status bit 7 at once. The next write gives a count, masked to DEV_BYTES*8 bits (BANK_BYTES*8 when DEV_BYTES is 0). A count of N-1 means N data words follow, each stored at its address. A following 0xD0 ends the sequence with status reads still selected.
- R8: After the buffered data words, any byte other than 0xD0 returns the machine to array mode.
- R9: Command 0x60 followed by 0xD0 or 0x01 returns the cycle counter to idle with status read selected and changes no data. Command 0x60 followed by any other byte, 0xFF included, selects array mode.
- R10: A first-cycle byte that is not a listed command selects array mode and clears the cycle counter.
- R11: While the current command is 0x10, 0x20, 0x28, 0x40, 0x50, 0x60, 0x70 or 0xE8, reads return the status register.
- R12: When BIG_ENDIAN is 1, the most significant byte of a bank word lives at the lowest byte address; when it is 0, the least significant byte does. A narrow write stores bus_wdata[7:0] in the lane given by the low address bits, and a narrow read returns that lane in bus_rdata[7:0] with zeros above.
- R13: A full-width status read places the status byte at byte 0 of every device-wide chunk (chunk = DEV_BYTES, or 2 bytes when DEV_BYTES is 0) and zeros elsewhere. A narrow status read returns status in the low byte.
- R14: rd_valid is high in the clock after each bus_rd, and bus_rdata holds the result during that clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe, one access per clock |
| bus_rd | input | 1 | Read strobe |
| bus_narrow | input | 1 | 1 = single-byte access, 0 = full bank word |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | BANK_BYTES*8 | Write data; command byte in bits 7:0 |
| wr_protect | input | 1 | Array write protect |
| bus_rdata | output | BANK_BYTES*8 | Read result, valid with rd_valid |
| rd_valid | output | 1 | Read result qualifier |
| read_mode | output | 2 | 0 array, 1 status, 2 identifier, 3 query |

## Verification
A write updates the command state, the status register and the array at the clock edge that samples it, so read_mode is checked at the falling edge right after that write. A read result is due exactly one clock after its strobe. The driver queues each expected word as it issues the read, and the monitor compares it at the falling edge where rd_valid is high. An erase sweep takes one clock per sector word, so status is read twice: a few cycles into the sweep, when bit 7 must be low, and again a fixed margin after the sweep length. Endianness, count masking and the protect paths are each observed only through later array or status reads.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

   typedef enum logic [1:0] {
      RM_ARRAY  = 2'd0,
      RM_STATUS = 2'd1,
      RM_IDENT  = 2'd2,
      RM_QUERY  = 2'd3
   } rmode_t;

   localparam logic [7:0] OP_PROG_A  = 8'h10;
   localparam logic [7:0] OP_PROG_B  = 8'h40;
   localparam logic [7:0] OP_ERASE_A = 8'h20;
   localparam logic [7:0] OP_ERASE_B = 8'h28;
   localparam logic [7:0] OP_CLEAR   = 8'h50;
   localparam logic [7:0] OP_LOCK    = 8'h60;
   localparam logic [7:0] OP_RSTAT   = 8'h70;
   localparam logic [7:0] OP_IDENT   = 8'h90;
   localparam logic [7:0] OP_QUERY   = 8'h98;
   localparam logic [7:0] OP_BUFWR   = 8'hE8;
   localparam logic [7:0] OP_CONFIRM = 8'hD0;
   localparam logic [7:0] OP_LOCKSET = 8'h01;
   localparam logic [7:0] OP_ARRAY   = 8'hFF;
   localparam logic [7:0] OP_ARRAY2  = 8'hF0;

   function automatic rmode_t mode_of(input logic [7:0] c);
      case (c)
         OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B,
         OP_CLEAR, OP_LOCK, OP_RSTAT, OP_BUFWR: mode_of = RM_STATUS;
         OP_IDENT: mode_of = RM_IDENT;
         OP_QUERY: mode_of = RM_QUERY;
         default:  mode_of = RM_ARRAY;
      endcase
   endfunction

   function automatic logic is_listed(input logic [7:0] c);
      case (c)
         OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B, OP_CLEAR, OP_LOCK,
         OP_RSTAT, OP_IDENT, OP_QUERY, OP_BUFWR, OP_ARRAY, OP_ARRAY2: is_listed = 1'b1;
         default: is_listed = 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/pfc_cmd.sv
module pfc_cmd
   import pfc_pkg::*;
#(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [CNT_W-1:0] wlow,
   input  logic             wp,
   input  logic             erase_busy,
   input  logic             erase_done,
   output logic             prog_we,
   output logic             erase_go,
   output rmode_t           rmode,
   output logic [7:0]       status
);

   if (CNT_W < 8) begin : g_bad_cnt
      $error("pfc_cmd: CNT_W must be at least 8");
   end

   logic [1:0]       wcyc;
   logic [7:0]       cmd;
   logic [CNT_W-1:0] cnt;
   logic [7:0]       op;
   logic             acc;
   logic             is_prog;
   logic             is_erase;

   assign op       = wlow[7:0];
   assign acc      = wr && !erase_busy;
   assign is_prog  = (cmd == OP_PROG_A) || (cmd == OP_PROG_B);
   assign is_erase = (cmd == OP_ERASE_A) || (cmd == OP_ERASE_B);
   assign prog_we  = acc && !wp && (((wcyc == 2'd1) && is_prog) || (wcyc == 2'd2));
   assign erase_go = acc && !wp && (wcyc == 2'd1) && is_erase && (op == OP_CONFIRM);
   assign rmode    = mode_of(cmd);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wcyc   <= 2'd0;
         cmd    <= 8'h00;
         status <= 8'h00;
         cnt    <= '0;
      end else begin
         if (erase_done) status[7] <= 1'b1;
         if (acc) begin
            case (wcyc)
               2'd0: begin
                  case (op)
                     OP_PROG_A, OP_PROG_B, OP_ERASE_A, OP_ERASE_B, OP_LOCK: begin
                        cmd  <= op;
                        wcyc <= 2'd1;
                     end
                     OP_BUFWR: begin
                        cmd    <= op;
                        wcyc   <= 2'd1;
                        status <= status | 8'h80;
                     end
                     OP_CLEAR: begin
                        cmd    <= op;
                        status <= 8'h00;
                     end
                     OP_RSTAT, OP_IDENT, OP_QUERY: cmd <= op;
                     default: cmd <= 8'h00;
                  endcase
               end
               2'd1: begin
                  if (is_prog) begin
                     status <= status | (wp ? 8'h90 : 8'h80);
                     wcyc   <= 2'd0;
                  end else if (is_erase) begin
                     wcyc <= 2'd0;
                     if (op == OP_CONFIRM)
                        status <= wp ? (status | 8'hA0) : (status & 8'h7F);
                     else
                        cmd <= 8'h00;
                  end else if (cmd == OP_LOCK) begin
                     wcyc <= 2'd0;
                     if (!((op == OP_CONFIRM) || (op == OP_LOCKSET))) cmd <= 8'h00;
                  end else if (cmd == OP_BUFWR) begin
                     cnt  <= wlow;
                     wcyc <= 2'd2;
                  end else begin
                     wcyc <= 2'd0;
                     cmd  <= 8'h00;
                  end
               end
               2'd2: begin
                  if (wp) status <= status | 8'h10;
                  if (cnt == '0) wcyc <= 2'd3;
                  else cnt <= cnt - 1'b1;
               end
               default: begin
                  wcyc <= 2'd0;
                  if (op != OP_CONFIRM) cmd <= 8'h00;
               end
            endcase
         end
      end
   end

   AST_PROG_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (wcyc == 2'd1) && is_prog) |=> status[7]); // R2
   AST_PROG_WP_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (wcyc == 2'd1) && is_prog && wp) |=> status[4]); // R5
   AST_BUF_READY: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (wcyc == 2'd0) && (op == OP_BUFWR)) |=> status[7]); // R7
   AST_UNKNOWN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && (wcyc == 2'd0) && !is_listed(op)) |=> ((wcyc == 2'd0) && (rmode == RM_ARRAY))); // R10

endmodule

// File: rtl/pfc_erase.sv
module pfc_erase #(
   parameter int WAW       = 9,
   parameter int SEC_WORDS = 128
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic [WAW-SW-1:0] sector,
   output logic              busy,
   output logic              done,
   output logic [WAW-1:0]    waddr
);

   localparam int SW = $clog2(SEC_WORDS);
   localparam logic [SW-1:0] LAST = SW'(SEC_WORDS - 1);

   if ((SEC_WORDS < 2) || ((1 << SW) != SEC_WORDS) || (SW >= WAW)) begin : g_bad_sec
      $error("pfc_erase: sector word count must be a power of two below the array depth");
   end

   logic [SW-1:0]     idx;
   logic [WAW-SW-1:0] sec_q;

   assign done  = busy && (idx == LAST);
   assign waddr = {sec_q, idx};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         idx   <= '0;
         sec_q <= '0;
      end else if (go && !busy) begin
         busy  <= 1'b1;
         idx   <= '0;
         sec_q <= sector;
      end else if (busy) begin
         idx <= idx + 1'b1;
         if (idx == LAST) busy <= 1'b0;
      end
   end

   AST_ERASE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> busy); // R3
   AST_ERASE_END: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !busy); // R3

endmodule

// File: rtl/pfc_array.sv
module pfc_array #(
   parameter int LANES = 2,
   parameter int AW    = 9
) (
   input  logic               clk,
   input  logic               we,
   input  logic [LANES-1:0]   lane_en,
   input  logic [AW-1:0]      waddr,
   input  logic [LANES*8-1:0] wlanes,
   input  logic               re,
   input  logic [AW-1:0]      raddr,
   output logic [LANES*8-1:0] rq
);

   localparam int DEPTH = 1 << AW;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic [7:0] mem [DEPTH];
      always_ff @(posedge clk) begin
         if (we && lane_en[i]) mem[waddr] <= wlanes[8*i +: 8];
      end
      always_ff @(posedge clk) begin
         if (re) rq[8*i +: 8] <= mem[raddr];
      end
   end

endmodule

// File: rtl/pflash_cmd_fsm.sv
module pflash_cmd_fsm
   import pfc_pkg::*;
#(
   parameter int BANK_BYTES   = 2,
   parameter int DEV_BYTES    = 1,
   parameter int ADDR_W       = 10,
   parameter int SECTOR_BYTES = 256,
   parameter bit BIG_ENDIAN   = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    bus_wr,
   input  logic                    bus_rd,
   input  logic                    bus_narrow,
   input  logic [ADDR_W-1:0]       bus_addr,
   input  logic [BANK_BYTES*8-1:0] bus_wdata,
   input  logic                    wr_protect,
   output logic [BANK_BYTES*8-1:0] bus_rdata,
   output logic                    rd_valid,
   output logic [1:0]              read_mode
);

   localparam int DW        = BANK_BYTES * 8;
   localparam int LB        = $clog2(BANK_BYTES);
   localparam int LBW       = (LB == 0) ? 1 : LB;
   localparam int WAW       = ADDR_W - LB;
   localparam int SEC_WORDS = SECTOR_BYTES / BANK_BYTES;
   localparam int SW        = $clog2(SEC_WORDS);
   localparam int CNT_W     = ((DEV_BYTES == 0) ? BANK_BYTES : DEV_BYTES) * 8;
   localparam int CHUNK     = (DEV_BYTES == 0) ? 2 : DEV_BYTES;

   if (!((BANK_BYTES == 1) || (BANK_BYTES == 2) || (BANK_BYTES == 4))) begin : g_bad_bank
      $error("pflash_cmd_fsm: BANK_BYTES must be 1, 2 or 4");
   end
   if (!((DEV_BYTES == 0) || (DEV_BYTES == 1) || (DEV_BYTES == 2) || (DEV_BYTES == 4))
       || (DEV_BYTES > BANK_BYTES)) begin : g_bad_dev
      $error("pflash_cmd_fsm: DEV_BYTES must be 0, 1, 2 or 4 and no wider than the bank");
   end
   if ((1 << $clog2(SECTOR_BYTES)) != SECTOR_BYTES) begin : g_bad_sector
      $error("pflash_cmd_fsm: SECTOR_BYTES must be a power of two");
   end

   rmode_t               rmode;
   logic [7:0]           status;
   logic                 prog_we;
   logic                 erase_go;
   logic                 erase_busy;
   logic                 erase_done;
   logic [WAW-1:0]       erase_addr;
   logic [WAW-1:0]       word_addr;
   logic [LBW-1:0]       lane;
   logic [DW-1:0]        map_w;
   logic [DW-1:0]        arr_word;
   logic [DW-1:0]        rq;
   logic [DW-1:0]        stat_rep;
   logic                 mem_we;
   logic [BANK_BYTES-1:0] mem_en;
   logic [WAW-1:0]       mem_waddr;
   logic [DW-1:0]        mem_wdata;

   logic                 narrow_q;
   logic [LBW-1:0]       lane_q;
   rmode_t               mode_q;
   logic [7:0]           stat_q;

   assign word_addr = bus_addr[ADDR_W-1:LB];
   assign lane      = (BANK_BYTES == 1) ? '0 : bus_addr[LBW-1:0];
   assign read_mode = rmode;

   pfc_cmd #(.CNT_W(CNT_W)) u_cmd (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr         (bus_wr),
      .wlow       (bus_wdata[CNT_W-1:0]),
      .wp         (wr_protect),
      .erase_busy (erase_busy),
      .erase_done (erase_done),
      .prog_we    (prog_we),
      .erase_go   (erase_go),
      .rmode      (rmode),
      .status     (status)
   );

   pfc_erase #(.WAW(WAW), .SEC_WORDS(SEC_WORDS)) u_erase (
      .clk    (clk),
      .rst_n  (rst_n),
      .go     (erase_go),
      .sector (word_addr[WAW-1:SW]),
      .busy   (erase_busy),
      .done   (erase_done),
      .waddr  (erase_addr)
   );

   for (genvar i = 0; i < BANK_BYTES; i++) begin : g_map
      localparam int SRC = BIG_ENDIAN ? (BANK_BYTES - 1 - i) : i;
      assign map_w[8*i +: 8]      = bus_wdata[8*SRC +: 8];
      assign arr_word[8*SRC +: 8] = rq[8*i +: 8];
      assign stat_rep[8*i +: 8]   = ((i % CHUNK) == 0) ? stat_q : 8'h00;
   end

   always_comb begin
      mem_we    = erase_busy || prog_we;
      mem_waddr = word_addr;
      mem_en    = '1;
      mem_wdata = map_w;
      if (erase_busy) begin
         mem_waddr = erase_addr;
         mem_wdata = '1;
      end else if (bus_narrow) begin
         mem_en    = '0;
         mem_en[lane] = 1'b1;
         mem_wdata = {BANK_BYTES{bus_wdata[7:0]}};
      end
   end

   pfc_array #(.LANES(BANK_BYTES), .AW(WAW)) u_array (
      .clk     (clk),
      .we      (mem_we),
      .lane_en (mem_en),
      .waddr   (mem_waddr),
      .wlanes  (mem_wdata),
      .re      (bus_rd),
      .raddr   (word_addr),
      .rq      (rq)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         narrow_q <= 1'b0;
         lane_q   <= '0;
         mode_q   <= RM_ARRAY;
         stat_q   <= 8'h00;
      end else begin
         rd_valid <= bus_rd;
         if (bus_rd) begin
            narrow_q <= bus_narrow;
            lane_q   <= lane;
            mode_q   <= rmode;
            stat_q   <= status;
         end
      end
   end

   always_comb begin
      bus_rdata = '0;
      case (mode_q)
         RM_ARRAY: begin
            if (narrow_q) bus_rdata[7:0] = rq[8*lane_q +: 8];
            else          bus_rdata      = arr_word;
         end
         RM_STATUS: begin
            if (narrow_q) bus_rdata[7:0] = stat_q;
            else          bus_rdata      = stat_rep;
         end
         default: bus_rdata = '0;
      endcase
   end

   AST_RD_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
      bus_rd |=> rd_valid); // R14
   AST_WP_NO_STORE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && !erase_busy) |-> !wr_protect); // R5

endmodule

// File: tb/pflash_cmd_fsm_test.sv
module pflash_cmd_fsm_test;

   localparam int SEC_WORDS = 128;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic        bus_narrow = 1'b0;
   logic [9:0]  bus_addr = '0;
   logic [15:0] bus_wdata = '0;
   logic        wr_protect = 1'b0;
   logic [15:0] bus_rdata;
   logic        rd_valid;
   logic [1:0]  read_mode;

   int checks = 0;
   int errors = 0;
   logic [15:0] exp_q[$];
   string       req_q[$];

   always #2 clk = ~clk;

   pflash_cmd_fsm #(
      .BANK_BYTES(2), .DEV_BYTES(1), .ADDR_W(10), .SECTOR_BYTES(256), .BIG_ENDIAN(1'b1)
   ) uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_narrow(bus_narrow),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .wr_protect(wr_protect),
      .bus_rdata(bus_rdata), .rd_valid(rd_valid), .read_mode(read_mode)
   );

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string req);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [9:0] a, input logic [15:0] d, input logic n = 1'b0);
      @(negedge clk);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_narrow = n;
      @(negedge clk);
      bus_wr = 1'b0; bus_narrow = 1'b0;
   endtask

   task automatic rd(input logic [9:0] a, input logic n, input logic [15:0] exp, input string req);
      @(negedge clk);
      exp_q.push_back(exp);
      req_q.push_back(req);
      bus_rd = 1'b1; bus_addr = a; bus_narrow = n;
      @(negedge clk);
      bus_rd = 1'b0; bus_narrow = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   always @(negedge clk) begin
      if (rst_n && rd_valid) begin
         if (exp_q.size() == 0) begin
            checks++; errors++;
            $display("FAIL R14: actual unexpected read result %h expected none", bus_rdata);
         end else begin
            logic [15:0] e;
            string r;
            e = exp_q.pop_front();
            r = req_q.pop_front();
            chk(bus_rdata, e, r);
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      idle(5);
      rst_n = 1'b1;
      idle(1);
      chk({14'd0, read_mode}, 16'd0, "R1 reset read mode");
      wr(10'h000, 16'h0070);
      chk({14'd0, read_mode}, 16'd1, "R6 status mode");
      rd(10'h000, 1'b0, 16'h0000, "R1 reset status");

      // R14: valid exactly one clock after strobe
      @(negedge clk);
      exp_q.push_back(16'h0000); req_q.push_back("R14 data");
      bus_rd = 1'b1;
      @(negedge clk);
      bus_rd = 1'b0;
      chk({15'd0, rd_valid}, 16'd1, "R14 valid high");
      @(negedge clk);
      chk({15'd0, rd_valid}, 16'd0, "R14 valid low");

      // R3 erase sector 0 through an unaligned address
      wr(10'h037, 16'h0028);
      wr(10'h037, 16'h00D0);
      rd(10'h000, 1'b0, 16'h0000, "R3 busy bit7 low");
      idle(SEC_WORDS + 4);
      rd(10'h000, 1'b0, 16'h8080, "R3 ready after sweep R13");
      wr(10'h000, 16'h00FF);
      rd(10'h000, 1'b0, 16'hFFFF, "R3 first word");
      rd(10'h0FE, 1'b0, 16'hFFFF, "R3 last word");
      wr(10'h1C0, 16'h0020);
      wr(10'h1C0, 16'h00D0);
      idle(SEC_WORDS + 4);
      wr(10'h000, 16'h00FF);

      // R2 program and R12 byte order
      wr(10'h010, 16'h0040);
      wr(10'h010, 16'hA1B2);
      rd(10'h000, 1'b0, 16'h8080, "R2 status after program");
      chk({14'd0, read_mode}, 16'd1, "R11 status mode after program");
      rd(10'h000, 1'b1, 16'h0080, "R13 narrow status");
      wr(10'h000, 16'h00FF);
      chk({14'd0, read_mode}, 16'd0, "R6 array mode");
      rd(10'h010, 1'b0, 16'hA1B2, "R2 stored word");
      rd(10'h010, 1'b1, 16'h00A1, "R12 low address is msb");
      rd(10'h011, 1'b1, 16'h00B2, "R12 high address is lsb");
      wr(10'h021, 16'h0010);
      wr(10'h021, 16'h005C, 1'b1);
      wr(10'h000, 16'h00FF);
      rd(10'h020, 1'b0, 16'hFF5C, "R12 narrow write lane");
      wr(10'h110, 16'h0010);
      wr(10'h110, 16'h1234);
      wr(10'h000, 16'h00FF);

      // R4 abort
      wr(10'h100, 16'h0020);
      wr(10'h100, 16'h00FF);
      chk({14'd0, read_mode}, 16'd0, "R4 abort mode");
      rd(10'h110, 1'b0, 16'h1234, "R4 data kept");

      // R3 neighbour untouched
      wr(10'h000, 16'h0020);
      wr(10'h000, 16'h00D0);
      idle(SEC_WORDS + 4);
      wr(10'h000, 16'h00FF);
      rd(10'h010, 1'b0, 16'hFFFF, "R3 erased word");
      rd(10'h110, 1'b0, 16'h1234, "R3 other sector kept");

      // R5 write protect
      wr_protect = 1'b1;
      wr(10'h000, 16'h0050);
      rd(10'h000, 1'b0, 16'h0000, "R6 clear status");
      wr(10'h040, 16'h0040);
      wr(10'h040, 16'h0000);
      rd(10'h000, 1'b0, 16'h9090, "R5 program error");
      wr(10'h000, 16'h00FF);
      rd(10'h040, 1'b0, 16'hFFFF, "R5 no store");
      wr(10'h000, 16'h0050);
      wr(10'h100, 16'h0020);
      wr(10'h100, 16'h00D0);
      rd(10'h000, 1'b0, 16'hA0A0, "R5 erase error");
      idle(4);
      wr(10'h000, 16'h00FF);
      rd(10'h110, 1'b0, 16'h1234, "R5 no erase");
      wr_protect = 1'b0;

      // R7 buffered write, count masked to 8 bits (0x0102 -> 2 -> 3 words)
      wr(10'h000, 16'h0050);
      wr(10'h080, 16'h00E8);
      rd(10'h000, 1'b0, 16'h8080, "R7 ready at once");
      wr(10'h080, 16'h0102);
      wr(10'h080, 16'h1111);
      wr(10'h082, 16'h2222);
      wr(10'h084, 16'h3333);
      wr(10'h086, 16'h00D0);
      chk({14'd0, read_mode}, 16'd1, "R7 confirm keeps status mode");
      wr(10'h000, 16'h00FF);
      rd(10'h080, 1'b0, 16'h1111, "R7 word0");
      rd(10'h082, 1'b0, 16'h2222, "R7 word1");
      rd(10'h084, 1'b0, 16'h3333, "R7 word2");
      rd(10'h086, 1'b0, 16'hFFFF, "R7 count masked");

      // R8 bad confirm
      wr(10'h088, 16'h00E8);
      wr(10'h088, 16'h0000);
      wr(10'h088, 16'h4444);
      wr(10'h088, 16'h0077);
      chk({14'd0, read_mode}, 16'd0, "R8 bad confirm to array");
      rd(10'h088, 1'b0, 16'h4444, "R8 single word stored");

      // R9 lock sequences
      wr(10'h000, 16'h0060);
      wr(10'h000, 16'h0001);
      chk({14'd0, read_mode}, 16'd1, "R9 lock accepted");
      wr(10'h000, 16'h00FF);
      wr(10'h000, 16'h0060);
      wr(10'h000, 16'h00D0);
      chk({14'd0, read_mode}, 16'd1, "R9 unlock accepted");
      wr(10'h000, 16'h0060);
      wr(10'h000, 16'h00FF);
      chk({14'd0, read_mode}, 16'd0, "R9 lock then FF");
      wr(10'h000, 16'h0060);
      wr(10'h000, 16'h0033);
      chk({14'd0, read_mode}, 16'd0, "R9 lock then other");
      rd(10'h080, 1'b0, 16'h1111, "R9 data kept");

      // R6 ident and query
      wr(10'h000, 16'h0090);
      chk({14'd0, read_mode}, 16'd2, "R6 ident mode");
      rd(10'h000, 1'b0, 16'h0000, "R6 ident reads zero");
      wr(10'h000, 16'h0098);
      chk({14'd0, read_mode}, 16'd3, "R6 query mode");
      rd(10'h000, 1'b0, 16'h0000, "R6 query reads zero");
      wr(10'h000, 16'h00F0);
      chk({14'd0, read_mode}, 16'd0, "R6 F0 array");

      // R10 unknown and R11 clear command reads status
      wr(10'h000, 16'h0050);
      chk({14'd0, read_mode}, 16'd1, "R11 clear reads status");
      wr(10'h000, 16'h003C);
      chk({14'd0, read_mode}, 16'd0, "R10 unknown to array");
      rd(10'h080, 1'b0, 16'h1111, "R10 array read");

      idle(3);
      chk(16'(exp_q.size()), 16'd0, "R14 all reads answered");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule